// File: doc/BRIEF.md
# Variable-length run-length event encoder

This block watches one single-bit signal on every clock tick and turns its history into a stream of variable-length codewords for a trace log. Each codeword holds the level that was held and how many ticks it was held for. Output is produced only when the level changes, when a run grows too long for the largest count field, or when the run in progress is flushed. The absolute time of any event can be rebuilt by adding up the run lengths, so no wide timestamp is stored per event.

Each codeword is right-aligned in `code_o`, and its bit count is given on `len_o`. The bit sent first is the most significant of the `len_o` bits. A codeword starts with the level bit `x` and is followed by a size prefix. There are three tiers:

- a single tick is `x 0` (2 bits);
- a medium run is `x 1 0` followed by a MID_W-bit field (default 5, 8 bits in total);
- a long run is `x 1 1` followed by a LONG_W-bit field (default 21, 24 bits in total).

Each count field holds the run length minus one. The control is a two-state machine. `S_IDLE` moves to `S_RUN` on `start_i`, and the tick sampled on that cycle begins the first run. `S_RUN` returns to `S_IDLE` on `flush_i`. In every other case `S_RUN` stays in `S_RUN`, and in that state it either extends the current run or closes it and opens a new one. Packing codewords into memory words is left to a downstream block.

Top module: `rle_encoder`

## Requirements
- R1: After reset `valid_o` is 0 and the block is in `S_IDLE`. In `S_IDLE` no codeword is produced, whatever `din_i` does, until `start_i` is seen.
- R2: On a rising edge in `S_IDLE` with `start_i`=1, the `din_i` value sampled at that edge becomes the first tick of the first run, and the block enters `S_RUN`.
- R3: A run of exactly one tick is emitted as `len_o`=2 and `code_o`={x,0}.
- R4: A run of 2 to 2^MID_W ticks is emitted as `len_o`=MID_W+3 and `code_o`={x,1,0,length-1 in MID_W bits}.
- R5: A run of 2^MID_W+1 to 2^LONG_W ticks is emitted as `len_o`=LONG_W+3 and `code_o`={x,1,1,length-1 in LONG_W bits}.
- R6: In `S_RUN`, a rising edge where `din_i` differs from the held level closes the run. Its codeword is on the outputs with `valid_o`=1 for the one cycle after that edge. The new value then starts a run of one tick. An edge that only extends a run produces no codeword.
- R7: When a run already holds 2^LONG_W ticks and the next sample has the same level, a long codeword with an all-ones count field is emitted. That sample starts a new run of the same level with a count of one.
- R8: `flush_i`=1 at a rising edge in `S_RUN` emits the run in progress in the next cycle, with the tier chosen from its count. The sample at that edge is discarded and the block returns to `S_IDLE`, after which it stays silent until the next start.
- R9: `start_i` has no effect while in `S_RUN`: the run in progress is neither restarted nor split.
- R10: A signal that toggles on every tick yields one 2-bit codeword on every cycle, with no tick lost.
- R11: Whenever `valid_o`=1, all bits of `code_o` at and above position `len_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `din_i` is sampled on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begins encoding from `S_IDLE` |
| flush_i | input | 1 | Emits the run in progress and returns to `S_IDLE` |
| din_i | input | 1 | Observed signal |
| code_o | output | CODE_W (24) | Right-aligned codeword |
| len_o | output | LEN_W (5) | Number of valid bits in `code_o` |
| valid_o | output | 1 | Codeword strobe, high for one cycle per codeword |

## Verification
Every codeword is due exactly one cycle after the rising edge that ends its run. That edge is the level change, the saturating sample or the flush. The codeword is visible from that edge until the next one. The bench drives inputs on the falling edge. At that moment its reference model pushes the expected codeword, tagged with the cycle number at which it is due. A monitor runs on each later falling edge. It compares the queue head when its due cycle matches, and it treats any strobe that arrives with no item due as a failure. The bench uses small count fields (3 and 8 bits), so the saturation and long-tier boundaries can be reached in a few hundred cycles.

// File: rtl/rle_pkg.sv
package rle_pkg;
    typedef enum logic {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } rle_state_e;
endpackage

// File: rtl/rle_run_tracker.sv
// Holds the level of the run in progress and its tick count.
module rle_run_tracker #(
    parameter int CNT_W = 22,
    parameter logic [CNT_W-1:0] CNT_MAX = 22'd2097152
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             inc_i,
    input  logic             din_i,
    output logic             level_q,
    output logic [CNT_W-1:0] count_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= 1'b0;
            count_q <= '0;
        end else if (load_i) begin
            level_q <= din_i;
            count_q <= ONE;
        end else if (inc_i) begin
            count_q <= count_q + ONE;
        end
    end

    // R7: the count never passes the largest long-tier length
    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CNT_MAX);

    // R7: extending a run is only requested below saturation
    p_inc_below_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> (count_q < CNT_MAX));

    // R6: a run is either closed or extended, never both
    p_single_action_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_i && inc_i));
endmodule

// File: rtl/rle_tier_coder.sv
// Picks the shortest tier for a run and forms the right-aligned codeword.
module rle_tier_coder #(
    parameter int MID_W  = 5,
    parameter int LONG_W = 21,
    parameter int CNT_W  = LONG_W + 1,
    parameter int CODE_W = LONG_W + 3,
    parameter int LEN_W  = $clog2(CODE_W + 1)
) (
    input  logic              level_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [CODE_W-1:0] code_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] MID_MAX = CNT_W'(1) << MID_W;

    logic [CNT_W-1:0]  minus1;
    logic [CODE_W-1:0] lvl_w;

    assign minus1 = count_i - ONE;
    assign lvl_w  = CODE_W'(level_i);

    always_comb begin
        if (count_i == ONE) begin
            code_o = lvl_w << 1;
            len_o  = LEN_W'(2);
        end else if (count_i <= MID_MAX) begin
            code_o = (lvl_w << (MID_W + 2))
                   | (CODE_W'(2) << MID_W)
                   | CODE_W'(minus1[MID_W-1:0]);
            len_o  = LEN_W'(MID_W + 3);
        end else begin
            code_o = (lvl_w << (LONG_W + 2))
                   | (CODE_W'(3) << LONG_W)
                   | CODE_W'(minus1[LONG_W-1:0]);
            len_o  = LEN_W'(CODE_W);
        end
    end
endmodule

// File: rtl/rle_encoder.sv
module rle_encoder
    import rle_pkg::*;
#(
    parameter int MID_W  = 5,
    parameter int LONG_W = 21,
    localparam int CODE_W = LONG_W + 3,
    localparam int LEN_W  = $clog2(CODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              flush_i,
    input  logic              din_i,
    output logic [CODE_W-1:0] code_o,
    output logic [LEN_W-1:0]  len_o,
    output logic              valid_o
);
    localparam int CNT_W = LONG_W + 1;
    localparam logic [CNT_W-1:0] RUN_MAX   = CNT_W'(1) << LONG_W;
    localparam logic [LEN_W-1:0] LEN_SHORT = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_MID   = LEN_W'(MID_W + 3);
    localparam logic [LEN_W-1:0] LEN_LONG  = LEN_W'(CODE_W);

    rle_state_e        state_q, state_d;
    logic              load, inc, emit;
    logic              level_q;
    logic [CNT_W-1:0]  count_q;
    logic [CODE_W-1:0] enc_code;
    logic [LEN_W-1:0]  enc_len;

    rle_run_tracker #(.CNT_W(CNT_W), .CNT_MAX(RUN_MAX)) u_tracker (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .inc_i   (inc),
        .din_i   (din_i),
        .level_q (level_q),
        .count_q (count_q)
    );

    rle_tier_coder #(
        .MID_W(MID_W), .LONG_W(LONG_W), .CNT_W(CNT_W),
        .CODE_W(CODE_W), .LEN_W(LEN_W)
    ) u_coder (
        .level_i (level_q),
        .count_i (count_q),
        .code_o  (enc_code),
        .len_o   (enc_len)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and run control
    always_comb begin
        state_d = state_q;
        load    = 1'b0;
        inc     = 1'b0;
        emit    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    load    = 1'b1;
                    state_d = S_RUN;
                end
            end
            S_RUN: begin
                if (flush_i) begin
                    emit    = 1'b1;
                    state_d = S_IDLE;
                end else if ((din_i != level_q) || (count_q == RUN_MAX)) begin
                    emit = 1'b1;
                    load = 1'b1;
                end else begin
                    inc = 1'b1;
                end
            end
        endcase
    end

    // Registered codeword outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            code_o  <= '0;
            len_o   <= '0;
        end else begin
            valid_o <= emit;
            if (emit) begin
                code_o <= enc_code;
                len_o  <= enc_len;
            end
        end
    end

    // R1: nothing is emitted after a cycle spent idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |=> !valid_o);

    // R6: a level change closes the run on the next cycle
    p_change_emits_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !flush_i && din_i != level_q) |=> valid_o);

    // R6: a run that is only extended stays silent
    p_hold_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !flush_i && din_i == level_q && count_q != RUN_MAX)
        |=> !valid_o);

    // R7: a saturated run produces a long codeword
    p_sat_long_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && !flush_i && count_q == RUN_MAX)
        |=> (valid_o && len_o == LEN_LONG));

    // R8: a flush emits and returns to idle
    p_flush_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RUN && flush_i) |=> (valid_o && state_q == S_IDLE));

    // R3: only the three tier lengths appear
    p_len_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (len_o == LEN_SHORT || len_o == LEN_MID || len_o == LEN_LONG));

    // R11: bits above the codeword length are zero
    p_code_clean_r11: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> ((code_o >> len_o) == '0));
endmodule

// File: tb/rle_encoder_bench.sv
`timescale 1ns/1ps
module rle_encoder_bench;
    localparam int MW   = 3;
    localparam int LW   = 8;
    localparam int CW   = LW + 3;
    localparam int LNW  = $clog2(CW + 1);
    localparam int MMAX = 1 << MW;
    localparam int LMAX = 1 << LW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic flush_i = 1'b0;
    logic din_i = 1'b0;
    logic [CW-1:0]  code_o;
    logic [LNW-1:0] len_o;
    logic           valid_o;

    always #2 clk = ~clk;   // 250 MHz

    rle_encoder #(.MID_W(MW), .LONG_W(LW)) u_rle_encoder (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .flush_i(flush_i),
        .din_i(din_i), .code_o(code_o), .len_o(len_o), .valid_o(valid_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit mon_on = 1'b0;
    string quiet_tag = "R1";

    int          due_q[$];
    logic [CW-1:0] code_q[$];
    int          len_q[$];
    string       tag_q[$];

    // reference model state
    bit    m_run = 1'b0;
    bit    m_lvl = 1'b0;
    int    m_cnt = 0;
    string m_tag = "";

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [CW-1:0] exp_code(bit lvl, int cnt);
        logic [CW-1:0] l = CW'(lvl);
        if (cnt == 1) return l << 1;
        if (cnt <= MMAX) return (l << (MW + 2)) | (CW'(2) << MW) | CW'(cnt - 1);
        return (l << (LW + 2)) | (CW'(3) << LW) | CW'(cnt - 1);
    endfunction

    function automatic int exp_len(int cnt);
        if (cnt == 1) return 2;
        if (cnt <= MMAX) return MW + 3;
        return LW + 3;
    endfunction

    task automatic push(string tg);
        due_q.push_back(cyc + 1);
        code_q.push_back(exp_code(m_lvl, m_cnt));
        len_q.push_back(exp_len(m_cnt));
        tag_q.push_back(tg);
    endtask

    // driver: one tick of stimulus plus the model's expectation
    task automatic tick(bit d, bit s, bit f, string tg);
        @(negedge clk);
        din_i = d; start_i = s; flush_i = f;
        if (!m_run) begin
            if (s) begin
                m_run = 1'b1; m_lvl = d; m_cnt = 1; m_tag = tg;
            end
        end else if (f) begin
            push("R8");
            m_run = 1'b0;
        end else if (d != m_lvl) begin
            push(m_tag);
            m_lvl = d; m_cnt = 1; m_tag = tg;
        end else if (m_cnt == LMAX) begin
            push("R7");
            m_cnt = 1; m_tag = tg;
        end else begin
            m_cnt++;
            m_tag = tg;
        end
    endtask

    task automatic hold(bit d, int n, string tg);
        for (int i = 0; i < n; i++) tick(d, 1'b0, 1'b0, tg);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mon_on) begin
                checks++;
                if (due_q.size() > 0 && due_q[0] == cyc) begin
                    if (!valid_o) begin
                        failures++;
                        $display("FAIL %s: valid=0 expected=1 code exp=%h len exp=%0d",
                                 tag_q[0], code_q[0], len_q[0]);
                    end else if (code_o !== code_q[0] || int'(len_o) != len_q[0]) begin
                        failures++;
                        $display("FAIL %s: code=%h len=%0d expected code=%h len=%0d",
                                 tag_q[0], code_o, len_o, code_q[0], len_q[0]);
                    end
                    if (valid_o) begin
                        checks++;   // R11
                        if ((code_o >> len_o) != '0) begin
                            failures++;
                            $display("FAIL R11: code=%h len=%0d expected upper bits 0",
                                     code_o, len_o);
                        end
                    end
                    void'(due_q.pop_front()); void'(code_q.pop_front());
                    void'(len_q.pop_front()); void'(tag_q.pop_front());
                end else if (valid_o) begin
                    failures++;
                    $display("FAIL %s: valid=1 code=%h len=%0d expected no codeword",
                             quiet_tag, code_o, len_o);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run not finished, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) begin
            @(negedge clk);
            checks++;
            if (valid_o !== 1'b0) begin
                failures++;
                $display("FAIL R1: valid=%b expected 0 in reset", valid_o);
            end
        end
        @(negedge clk); rst_n = 1'b1;
        mon_on = 1'b1;
        quiet_tag = "R1";
        hold(1'b1, 2, ""); hold(1'b0, 3, ""); hold(1'b1, 1, "");   // idle, no start
        quiet_tag = "R6";

        tick(1'b1, 1'b1, 1'b0, "R2");        // R2: first run, 5 ticks
        hold(1'b1, 4, "R2");
        hold(1'b0, 1, "R3");                 // R3: single tick
        hold(1'b1, 2, "R4");                 // R4: lower medium bound
        hold(1'b0, MMAX, "R4");              // R4: upper medium bound
        hold(1'b1, MMAX + 1, "R5");          // R5: lower long bound
        for (int i = 0; i < 21; i++)         // R10: toggle every tick
            tick(bit'(i % 2), 1'b0, 1'b0, "R10");
        hold(1'b1, 2, "R9");                 // R9: start ignored mid-run
        tick(1'b1, 1'b1, 1'b0, "R9");
        hold(1'b1, 3, "R9");
        hold(1'b0, 100, "R5");               // R5: longer long run
        hold(1'b1, LMAX + 10, "R7");         // R7: saturation then continue
        hold(1'b0, 4, "R8");                 // R8: flush a medium run
        tick(1'b0, 1'b0, 1'b1, "");
        quiet_tag = "R8";
        hold(1'b1, 2, ""); hold(1'b0, 2, "");
        quiet_tag = "R6";
        tick(1'b1, 1'b1, 1'b0, "R2");        // restart, flush a single tick
        tick(1'b1, 1'b0, 1'b1, "");
        quiet_tag = "R8";
        hold(1'b0, 3, "");

        repeat (2) @(negedge clk);
        checks++;
        if (due_q.size() != 0) begin
            failures++;
            $display("FAIL R6: %0d codewords outstanding expected 0", due_q.size());
        end
        done = 1'b1;
        mon_on = 1'b0;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule